// File: doc/BRIEF.md
# Phase-Frequency Detector with Reference-Loss Guard

This block is the digital core of a clock-recovery loop. It watches two rising-edge strobes, one from the chosen reference wordclock and one from the wordclock divided down from the VCO, and turns their timing into correction pulses for a charge pump or an active loop filter. A reference edge arms the pump-up state and a feedback edge arms the pump-down state. When both are armed, both clear. Each pulse therefore lasts, in system clocks, as long as the edge-to-edge phase error. When the loop is far from lock, one direction keeps firing with pulse widths that change over time. Near lock, the widths follow the phase offset.

Both strobes are synchronous, single-cycle pulses in a fast system clock domain. A timeout counter measures how long it has been since the last reference edge. When it reaches a programmable limit, the block declares the reference missing. While the reference is missing, the pump-down output is held inactive, so the filter is not driven toward zero VCO frequency. The next reference edge clears the condition.

Top module: `pfd_lossguard`

## Requirements
- R1: In reset and on the first cycle after it, pumpUp is 0, pumpDownN is 1 and refLost is 1; no reference edge has been seen yet, so the reference counts as absent.
- R2: A reference strobe taken on one clock edge, with no feedback strobe and no armed pump-down state, drives pumpUp high after that edge. pumpUp stays high until the clock edge that takes the next feedback strobe, so it is high for exactly that many cycles.
- R3: While refLost is 0, a feedback strobe with no armed pump-up state drives pumpDownN low (active-low). It stays low until the clock edge that takes the next reference strobe.
- R4: Reference and feedback strobes in the same cycle count as coincident. After that edge both outputs are inactive (pumpUp 0, pumpDownN 1), whatever the earlier state.
- R5: pumpUp high and pumpDownN low never occur in the same cycle.
- R6: When the feedback period is longer than the reference period (VCO too slow), only pumpUp pulses appear, and their widths change from pulse to pulse.
- R7: When the feedback period is shorter than the reference period (VCO too fast), only pumpDownN pulses appear.
- R8: refLost rises after the clock edge that comes lossLimit edges after the last reference strobe was taken, if no reference strobe arrives in between. Before that edge it stays 0. A lossLimit of 0 acts like 1.
- R9: While refLost is 1, pumpDownN stays 1 even when feedback strobes arrive.
- R10: A reference strobe clears refLost after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refEdge | input | 1 | One-cycle strobe for a rising edge of the reference wordclock |
| fbEdge | input | 1 | One-cycle strobe for a rising edge of the divided VCO wordclock |
| lossLimit | input | CNT_W | Number of cycles without a reference edge before the reference counts as lost |
| pumpUp | output | 1 | Active-high raise-frequency pulse |
| pumpDownN | output | 1 | Active-low lower-frequency pulse |
| refLost | output | 1 | High while the reference counts as absent |

## Verification
A wrong pump state appears on pumpUp or pumpDownN one cycle after the strobe that should have changed it. A missed clear leaves a pulse one cycle too long, or leaves the opposite output stuck, and this shows up at the next strobe. A fault in the timeout counter only becomes visible at the limit edge, or at the first feedback strobe after it, where an unguarded pumpDownN drops low. For this reason the bench checks the loss flag exactly at limit−1 and at the limit, and then sends feedback strobes into the lost state. A behavioural model of signed phase with a clamp predicts all three outputs every cycle, so a difference is reported in the cycle it first appears.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Strobes passed from the control block to the datapath each cycle
  typedef struct packed {
    logic refHit;   // reference edge taken this cycle
    logic fbHit;    // feedback edge taken this cycle
    logic guardDn;  // reference absent: mask pump-down
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [CNT_W-1:0] lossLimit,
  output pfdStrobe_t       strobe,
  output logic             refLost
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] idleCnt;
  logic [EXT_W-1:0] idleNext;
  logic             limitHit;
  logic             lostQ;

  assign idleNext = {1'b0, idleCnt} + EXT_W'(1);
  assign limitHit = idleNext >= {1'b0, lossLimit};

  // Timeout counter: cycles since the last reference edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idleCnt <= '0;
      lostQ   <= 1'b1;
    end else if (refEdge) begin
      idleCnt <= '0;
      lostQ   <= 1'b0;
    end else if (!lostQ) begin
      if (limitHit) lostQ <= 1'b1;
      else          idleCnt <= idleNext[CNT_W-1:0];
    end
  end

  always_comb begin
    strobe.refHit  = refEdge;
    strobe.fbHit   = fbEdge;
    strobe.guardDn = lostQ;
  end

  assign refLost = lostQ;

  // R10: a reference edge always ends the lost state
  p_loss_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    refEdge |=> !refLost);

  // R8: once lost, the flag holds until a reference edge arrives
  p_loss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refLost && !refEdge) |=> refLost);

  // R8: the counter never passes the limit while the reference is present
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!refLost && lossLimit != '0) |-> (idleCnt < lossLimit));
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfdStrobe_t strobe,
  output logic       pumpUp,
  output logic       pumpDownN
);
  logic upQ, dnQ;
  logic upSet, dnSet;
  logic upNext, dnNext;

  // When both states would be armed, they cancel in the same cycle
  always_comb begin
    upSet = upQ | strobe.refHit;
    dnSet = dnQ | strobe.fbHit;
    if (upSet && dnSet) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end else begin
      upNext = upSet;
      dnNext = dnSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end

  assign pumpUp    = upQ;
  assign pumpDownN = ~(dnQ & ~strobe.guardDn);

  // R5: the two pump states are never armed together
  p_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(upQ && dnQ));

  // R4: coincident edges leave both states cleared
  p_coincident_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.refHit && strobe.fbHit) |=> (!upQ && !dnQ));

  // R2: a lone reference edge with nothing pending on the down side arms up
  p_up_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.refHit && !strobe.fbHit && !dnQ) |=> upQ);

  // R3: a lone feedback edge with nothing pending on the up side arms down
  p_dn_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fbHit && !strobe.refHit && !upQ) |=> dnQ);
endmodule

// File: rtl/pfd_lossguard.sv
module pfd_lossguard
  import pfd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [CNT_W-1:0] lossLimit,
  output logic             pumpUp,
  output logic             pumpDownN,
  output logic             refLost
);
  pfdStrobe_t strobe;

  pfd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .refEdge   (refEdge),
    .fbEdge    (fbEdge),
    .lossLimit (lossLimit),
    .strobe    (strobe),
    .refLost   (refLost)
  );

  pfd_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .pumpUp    (pumpUp),
    .pumpDownN (pumpDownN)
  );

  // R9: pump-down is never active while the reference counts as lost
  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refLost |-> pumpDownN);

  // R5: the outputs are never active together
  p_out_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pumpUp && !pumpDownN));
endmodule

// File: tb/pfd_lossguard_test.sv
`timescale 1ns/100ps
module pfd_lossguard_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             refEdge = 1'b0;
  logic             fbEdge = 1'b0;
  logic [CNT_W-1:0] lossLimit = CNT_W'(40);
  logic             pumpUp, pumpDownN, refLost;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model: signed phase, clamped to -1..1, plus idle counter
  int mPhase = 0;
  int mIdle = 0;
  bit mLost = 1;

  always #2.5 clk = ~clk;

  pfd_lossguard #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .refEdge(refEdge), .fbEdge(fbEdge),
    .lossLimit(lossLimit), .pumpUp(pumpUp), .pumpDownN(pumpDownN),
    .refLost(refLost)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; mIdle = 0; mLost = 1;
    end else begin
      if (refEdge && fbEdge) mPhase = 0;
      else begin
        mPhase = mPhase + int'(refEdge) - int'(fbEdge);
        if (mPhase > 1) mPhase = 1;
        if (mPhase < -1) mPhase = -1;
      end
      if (refEdge) begin mIdle = 0; mLost = 0; end
      else if (!mLost) begin
        mIdle++;
        if (mIdle >= ((lossLimit == 0) ? 1 : int'(lossLimit))) mLost = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(pumpUp == (mPhase > 0), "R2 pumpUp model", int'(pumpUp), int'(mPhase > 0));
      check(pumpDownN == !(mPhase < 0 && !mLost), "R3/R9 pumpDownN model",
            int'(pumpDownN), int'(!(mPhase < 0 && !mLost)));
      check(refLost == mLost, "R8 refLost model", int'(refLost), int'(mLost));
      check(!(pumpUp && !pumpDownN), "R5 exclusive", int'(pumpUp), 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=finished", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step(input bit r, input bit f);
    refEdge = r;
    fbEdge = f;
    @(negedge clk);
  endtask

  int upCnt, dnCnt, lastW, w, widthsSeen;

  initial begin
    repeat (3) @(negedge clk);
    check(pumpUp == 0 && pumpDownN == 1 && refLost == 1, "R1 reset state",
          {pumpUp, pumpDownN, refLost}, 3'b011);
    rst_n = 1'b1;
    step(0, 0);
    check(pumpUp == 0 && pumpDownN == 1 && refLost == 1, "R1 after reset",
          {pumpUp, pumpDownN, refLost}, 3'b011);

    // R2: reference leads by 5 cycles
    step(1, 0);
    w = 0;
    for (int i = 0; i < 5; i++) begin
      if (pumpUp) w++;
      step(0, i == 4);
    end
    check(w == 5, "R2 up width", w, 5);
    check(pumpUp == 0, "R2 up ends", int'(pumpUp), 0);

    // R3: feedback leads by 4 cycles, reference present
    step(0, 1);
    w = 0;
    for (int i = 0; i < 4; i++) begin
      if (!pumpDownN) w++;
      step(i == 3, 0);
    end
    check(w == 4, "R3 down width", w, 4);
    check(pumpDownN == 1, "R3 down ends", int'(pumpDownN), 1);

    // R4: coincident edges, idle and with up pending
    step(1, 1);
    check(pumpUp == 0 && pumpDownN == 1, "R4 coincident idle", int'(pumpUp), 0);
    step(1, 0);
    step(1, 1);
    check(pumpUp == 0 && pumpDownN == 1, "R4 coincident over up", int'(pumpUp), 0);
    step(0, 1);
    step(1, 1);
    check(pumpUp == 0 && pumpDownN == 1, "R4 coincident over down", int'(pumpDownN), 1);

    // R6: VCO slow (ref period 10, fb period 11)
    upCnt = 0; dnCnt = 0; lastW = -1; w = 0; widthsSeen = 0;
    for (int i = 0; i < 100; i++) begin
      step(i % 10 == 0, i % 11 == 0);
      if (pumpUp) begin upCnt++; w++; end
      else if (w != 0) begin
        if (w != lastW) widthsSeen++;
        lastW = w; w = 0;
      end
      if (!pumpDownN) dnCnt++;
    end
    check(dnCnt == 0, "R6 no down when slow", dnCnt, 0);
    check(upCnt > 0 && widthsSeen > 2, "R6 varying up widths", widthsSeen, 3);
    step(0, 1);

    // R7: VCO fast (ref period 11, fb period 10)
    step(1, 1);
    upCnt = 0; dnCnt = 0;
    for (int i = 0; i < 100; i++) begin
      step(i % 11 == 0, i % 10 == 0);
      if (pumpUp) upCnt++;
      if (!pumpDownN) dnCnt++;
    end
    check(upCnt == 0 && dnCnt > 0, "R7 only down when fast", upCnt, 0);
    step(1, 1);

    // R8: loss timeout with limit 20
    lossLimit = CNT_W'(20);
    step(1, 1);
    for (int i = 0; i < 19; i++) step(0, 0);
    check(refLost == 0, "R8 not lost at limit-1", int'(refLost), 0);
    step(0, 0);
    check(refLost == 1, "R8 lost at limit", int'(refLost), 1);

    // R9: feedback edges while lost do not pull pump-down
    for (int i = 0; i < 3; i++) begin
      step(0, 1);
      check(pumpDownN == 1, "R9 guard holds", int'(pumpDownN), 1);
      step(0, 0);
    end

    // R10: the next reference edge clears the loss flag
    step(1, 0);
    check(refLost == 0, "R10 loss clears", int'(refLost), 0);
    step(0, 1);
    step(0, 0);

    // R8: zero limit behaves like one
    lossLimit = '0;
    step(1, 1);
    check(refLost == 0, "R8 zero limit ref", int'(refLost), 0);
    step(0, 0);
    check(refLost == 1, "R8 zero limit lost", int'(refLost), 1);
    step(1, 1);
    step(0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule